// File: doc/BRIEF.md
# Page Memory Access and Lock Controller

This block stands between a command decoder and a small page memory of 48 words, each 32 bits wide. The memory is kept inside the block as a register array. The decoder issues two kinds of request:

- A page read returns four consecutive pages in one 128-bit response.
- A page write stores a single 32-bit page.

Each request produces exactly one response in the following cycle. The response carries either the read data or an acknowledge, or it carries a negative-acknowledge flag.

Write protection works on three levels:

- Per-page lock bits guard pages 03h to 0Fh.
- Block-lock bits freeze groups of those lock bits.
- The lock page and the one-time-programmable page can only gain set bits.

Access control relies on a threshold page stored in memory, together with a mode bit that chooses between protecting writes only and protecting both reads and writes. The authentication result comes from outside on the `authed` input. Lock settings are captured into a working copy only when `activate` pulses, which marks a card activation event.

The bench drives requests through the decoder-side port and compares every response against values worked out from the rules below.

Top module: `page_guard`

## Requirements
- R1: After reset, no response is issued without a request, and every page reads as zero except the threshold page 2Ah, whose byte 0 (bits 7:0) is 30h.
- R2: A read of start page P that is accepted returns pages P, P+1, P+2 and P+3, with page P in `resp_rdata[31:0]` and each following page in the next 32 bits. The response appears in the cycle after the request, with `resp_nak` low.
- R3: A read whose start page is above 2Bh returns a NAK.
- R4: A read that runs past page 2Bh continues at page 00h. For example, start 29h gives 29h, 2Ah, 2Bh, 00h.
- R5: Read protection applies when `authed` is low and bit 0 of page 2Bh is 0. In that case a read at or above the threshold (page 2Ah bits 7:0) returns a NAK, and a read below the threshold wraps to page 00h before reaching the threshold page. When `authed` is high, no threshold restriction applies.
- R6: When bit 0 of page 2Bh is 1, reads ignore the threshold. A write at or above the threshold still returns a NAK while `authed` is low.
- R7: A write is accepted only for pages 02h to 2Fh. Any other address returns a NAK and leaves memory unchanged. An accepted write returns an ACK.
- R8: Pages 2Ch to 2Fh accept writes, but a read never returns their contents.
- R9: A write to page 02h leaves bits 15:0 unchanged and ORs bits 31:16 into the stored lock field.
- R10: A write to page 03h ORs the new data into the stored word, so its bits only go from 0 to 1.
- R11: Bit k of the lock field (page 02h bit 16+k) locks page k, for k from 3 to 15. A write to a locked page returns a NAK and leaves the page unchanged.
- R12: The lock field bits 0, 1 and 2 are block-lock bits. Once set, they freeze the lock bit for page 03h, the lock bits for pages 04h–09h, and the lock bits for pages 0Ah–0Fh respectively. A write that tries to set a frozen bit is acknowledged but has no effect on that bit.
- R13: Lock and block-lock decisions use a copy of the lock field taken at the last `activate` pulse. A lock value written later has no effect until the next pulse.
- R14: Byte 3 of page 28h (bits 31:24) always reads as BDh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = page write, 0 = four-page read |
| req_page | input | 8 | Page address |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| authed | input | 1 | Authentication already succeeded |
| activate | input | 1 | Activation event pulse; captures the lock field |
| resp_valid | output | 1 | Response strobe |
| resp_nak | output | 1 | 1 = NAK, 0 = ACK or valid read data |
| resp_rdata | output | 128 | Four read pages, first page in bits 31:0 |

## Verification
Some behaviours are checked by assertions on every cycle:

- A response follows every request and nothing else.
- Out-of-range reads and writes are refused.
- Protected accesses and writes to locked pages return a NAK.
- The lock word and the one-time-programmable word only gain set bits.
- The working lock copy changes only on an activation pulse.

Other behaviours can only be shown by the bench's scenarios, because they concern data content:

- The exact page order in a burst, including both wrap points.
- The BDh byte of page 28h.
- Hiding of the key pages.
- Freezing of lock bits that are under a block lock.
- The delay in lock settings taking effect until the next activation.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int PAGE_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int BURST   = 4;
  localparam int RESP_W  = BURST * PAGE_W;
  localparam int LOCK_W  = 16;

  localparam logic [ADDR_W-1:0] READ_TOP   = 8'h2B;
  localparam logic [ADDR_W-1:0] READ_END   = READ_TOP + 8'd1;
  localparam logic [ADDR_W-1:0] WRITE_LOW  = 8'h02;
  localparam logic [ADDR_W-1:0] WRITE_TOP  = 8'h2F;
  localparam logic [ADDR_W-1:0] LOCK_PG    = 8'h02;
  localparam logic [ADDR_W-1:0] OTP_PG     = 8'h03;
  localparam logic [ADDR_W-1:0] LAST_LOCKABLE = 8'h0F;
  localparam logic [ADDR_W-1:0] CFG_PG     = 8'h28;
  localparam logic [ADDR_W-1:0] THRESH_PG  = 8'h2A;
  localparam logic [ADDR_W-1:0] MODE_PG    = 8'h2B;
  localparam logic [ADDR_W-1:0] THRESH_OFF = 8'h30;
  localparam logic [7:0]        CFG_FILL   = 8'hBD;

  typedef enum logic [1:0] {
    WK_PLAIN = 2'd0,
    WK_LOCK  = 2'd1,
    WK_OTP   = 2'd2
  } wkind_t;
endpackage

// File: rtl/pg_lock_ctrl.sv
module pg_lock_ctrl
  import pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              activate,
  input  logic [LOCK_W-1:0] stored_lock,
  input  logic [ADDR_W-1:0] page,
  output logic [LOCK_W-1:0] eff_lock,
  output logic [LOCK_W-1:0] freeze_mask,
  output logic              page_locked
);
  localparam int GRP0_LO = 3;
  localparam int GRP1_LO = 4;
  localparam int GRP1_HI = 9;
  localparam int GRP2_LO = 10;

  logic [LOCK_W-1:0] eff_q, eff_d;

  always_comb begin
    eff_d = eff_q;
    if (activate) eff_d = stored_lock;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) eff_q <= '0;
    else         eff_q <= eff_d;
  end

  assign eff_lock = eff_q;

  // block-lock bits 0..2 freeze the matching per-page lock bits
  for (genvar b = 0; b < LOCK_W; b++) begin : g_frz
    if (b == GRP0_LO) begin : g_b0
      assign freeze_mask[b] = eff_q[0];
    end else if (b >= GRP1_LO && b <= GRP1_HI) begin : g_b1
      assign freeze_mask[b] = eff_q[1];
    end else if (b >= GRP2_LO) begin : g_b2
      assign freeze_mask[b] = eff_q[2];
    end else begin : g_none
      assign freeze_mask[b] = 1'b0;
    end
  end

  always_comb begin
    page_locked = 1'b0;
    if (page >= OTP_PG && page <= LAST_LOCKABLE)
      page_locked = eff_q[page[$clog2(LOCK_W)-1:0]];
  end
endmodule

// File: rtl/pg_read_seq.sv
module pg_read_seq
  import pg_pkg::*;
(
  input  logic [ADDR_W-1:0]       start,
  input  logic [ADDR_W-1:0]       limit,
  output logic [BURST*ADDR_W-1:0] page_list
);
  logic [ADDR_W-1:0] cur;

  always_comb begin
    cur = start;
    page_list = '0;
    for (int i = 0; i < BURST; i++) begin
      page_list[i*ADDR_W +: ADDR_W] = cur;
      cur = ((cur + 8'd1) >= limit) ? '0 : cur + 8'd1;
    end
  end
endmodule

// File: rtl/pg_write_merge.sv
module pg_write_merge
  import pg_pkg::*;
(
  input  wkind_t            kind,
  input  logic [PAGE_W-1:0] old_word,
  input  logic [PAGE_W-1:0] new_word,
  input  logic [LOCK_W-1:0] freeze_mask,
  output logic [PAGE_W-1:0] merged
);
  localparam int KEEP_W = PAGE_W - LOCK_W;

  always_comb begin
    case (kind)
      WK_LOCK: merged = {old_word[PAGE_W-1:KEEP_W]
                         | (new_word[PAGE_W-1:KEEP_W] & ~freeze_mask),
                         old_word[KEEP_W-1:0]};
      WK_OTP:  merged = old_word | new_word;
      default: merged = new_word;
    endcase
  end
endmodule

// File: rtl/page_guard.sv
module page_guard
  import pg_pkg::*;
#(
  parameter int NUM_PAGES = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_page,
  input  logic [PAGE_W-1:0] req_wdata,
  input  logic              authed,
  input  logic              activate,
  output logic              resp_valid,
  output logic              resp_nak,
  output logic [RESP_W-1:0] resp_rdata
);
  localparam int PIDX_W = $clog2(NUM_PAGES);
  localparam int KEEP_W = PAGE_W - LOCK_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  logic [PAGE_W-1:0] mem_q [NUM_PAGES];

  logic [ADDR_W-1:0] thresh;
  logic              write_only_mode;
  logic [LOCK_W-1:0] lock_word;
  logic [PAGE_W-1:0] otp_word;
  assign thresh          = mem_q[THRESH_PG][ADDR_W-1:0];
  assign write_only_mode = mem_q[MODE_PG][0];
  assign lock_word       = mem_q[LOCK_PG][PAGE_W-1:KEEP_W];
  assign otp_word        = mem_q[OTP_PG];

  // lock state
  logic [LOCK_W-1:0] eff_lock, freeze_mask;
  logic              page_locked;

  pg_lock_ctrl u_lock (
    .clk         (clk),
    .rst_ns      (rst_ns),
    .activate    (activate),
    .stored_lock (lock_word),
    .page        (req_page),
    .eff_lock    (eff_lock),
    .freeze_mask (freeze_mask),
    .page_locked (page_locked)
  );

  // read path
  logic              rd_prot, rd_nak;
  logic [ADDR_W-1:0] rd_limit;
  logic [BURST*ADDR_W-1:0] page_list;
  logic [RESP_W-1:0] rd_data;

  assign rd_prot  = !authed && !write_only_mode;
  assign rd_limit = (rd_prot && thresh < READ_END) ? thresh : READ_END;
  assign rd_nak   = (req_page > READ_TOP) || (rd_prot && req_page >= thresh);

  pg_read_seq u_seq (
    .start     (req_page),
    .limit     (rd_limit),
    .page_list (page_list)
  );

  for (genvar i = 0; i < BURST; i++) begin : g_rd
    logic [ADDR_W-1:0] pg;
    logic [PAGE_W-1:0] word;
    assign pg = page_list[i*ADDR_W +: ADDR_W];
    always_comb begin
      word = mem_q[pg[PIDX_W-1:0]];
      if (pg == CFG_PG) word[PAGE_W-1 -: 8] = CFG_FILL;
    end
    assign rd_data[i*PAGE_W +: PAGE_W] = word;
  end

  // write path
  logic              wr_nak, wr_en;
  logic [PIDX_W-1:0] widx;
  wkind_t            wkind;
  logic [PAGE_W-1:0] wr_word;

  assign widx   = req_page[PIDX_W-1:0];
  assign wr_nak = (req_page < WRITE_LOW) || (req_page > WRITE_TOP)
                  || (!authed && req_page >= thresh) || page_locked;
  assign wr_en  = req_valid && req_write && !wr_nak;

  always_comb begin
    if (req_page == LOCK_PG)     wkind = WK_LOCK;
    else if (req_page == OTP_PG) wkind = WK_OTP;
    else                         wkind = WK_PLAIN;
  end

  pg_write_merge u_merge (
    .kind        (wkind),
    .old_word    (mem_q[widx]),
    .new_word    (req_wdata),
    .freeze_mask (freeze_mask),
    .merged      (wr_word)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int g = 0; g < NUM_PAGES; g++)
        mem_q[g] <= (g == int'(THRESH_PG)) ? {{(PAGE_W-ADDR_W){1'b0}}, THRESH_OFF}
                                           : '0;
    end else if (wr_en) begin
      mem_q[widx] <= wr_word;
    end
  end

  // response
  logic              rv_d, rn_d;
  logic [RESP_W-1:0] rd_d;

  always_comb begin
    rv_d = req_valid;
    rn_d = req_write ? wr_nak : rd_nak;
    rd_d = (req_write || rd_nak) ? '0 : rd_data;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      resp_valid <= 1'b0;
      resp_nak   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= rv_d;
      if (req_valid) begin
        resp_nak   <= rn_d;
        resp_rdata <= rd_d;
      end
    end
  end
endmodule

// File: rtl/pg_checker.sv
module pg_checker
  import pg_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_page,
  input logic              authed,
  input logic              activate,
  input logic              resp_valid,
  input logic              resp_nak,
  input logic [LOCK_W-1:0] eff_lock,
  input logic [LOCK_W-1:0] lock_word,
  input logic [PAGE_W-1:0] otp_word,
  input logic [ADDR_W-1:0] thresh,
  input logic              write_only_mode
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid |=> resp_valid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_valid |=> !resp_valid); // R1
  AST_READ_RANGE_NAK: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && !req_write && req_page > READ_TOP) |=> resp_nak); // R3
  AST_PROT_READ_NAK: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && !req_write && !authed && !write_only_mode && req_page >= thresh)
    |=> resp_nak); // R5
  AST_PROT_WRITE_NAK: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_write && !authed && req_page >= thresh) |=> resp_nak); // R6
  AST_WRITE_RANGE_NAK: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_write && (req_page < WRITE_LOW || req_page > WRITE_TOP))
    |=> resp_nak); // R7
  AST_LOCK_WORD_GROWS: assert property (@(posedge clk) disable iff (!rst_ns)
    (lock_word & $past(lock_word)) == $past(lock_word)); // R9
  AST_OTP_GROWS: assert property (@(posedge clk) disable iff (!rst_ns)
    (otp_word & $past(otp_word)) == $past(otp_word)); // R10
  AST_LOCKED_PAGE_NAK: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_write && req_page >= OTP_PG && req_page <= LAST_LOCKABLE
     && eff_lock[req_page[3:0]]) |=> resp_nak); // R11
  AST_LOCK_COPY_HOLDS: assert property (@(posedge clk) disable iff (!rst_ns)
    !activate |=> $stable(eff_lock)); // R13
endmodule

bind page_guard pg_checker u_chk (
  .clk             (clk),
  .rst_ns          (rst_ns),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .req_page        (req_page),
  .authed          (authed),
  .activate        (activate),
  .resp_valid      (resp_valid),
  .resp_nak        (resp_nak),
  .eff_lock        (eff_lock),
  .lock_word       (lock_word),
  .otp_word        (otp_word),
  .thresh          (thresh),
  .write_only_mode (write_only_mode)
);

// File: tb/page_guard_bench.sv
module page_guard_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [7:0]   req_page = '0;
  logic [31:0]  req_wdata = '0;
  logic         authed = 1'b0;
  logic         activate = 1'b0;
  logic         resp_valid;
  logic         resp_nak;
  logic [127:0] resp_rdata;

  int checks = 0;
  int errors = 0;

  bit           q_nak [$];
  logic [127:0] q_data [$];
  bit           q_chkd [$];
  string        q_tag [$];

  always #2.5 clk = ~clk;

  page_guard u_page_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_page   (req_page),
    .req_wdata  (req_wdata),
    .authed     (authed),
    .activate   (activate),
    .resp_valid (resp_valid),
    .resp_nak   (resp_nak),
    .resp_rdata (resp_rdata)
  );

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      checks++;
      if (q_nak.size() == 0) begin
        errors++;
        $display("FAIL R2: response with nothing expected nak=%0b data=%h expected none",
                 resp_nak, resp_rdata);
      end else begin
        automatic bit           en = q_nak.pop_front();
        automatic logic [127:0] ed = q_data.pop_front();
        automatic bit           ck = q_chkd.pop_front();
        automatic string        tg = q_tag.pop_front();
        if (resp_nak !== en || (ck && resp_rdata !== ed)) begin
          errors++;
          $display("FAIL %s: nak=%0b data=%h expected nak=%0b data=%h",
                   tg, resp_nak, resp_rdata, en, ed);
        end
      end
    end
  end

  task automatic send(input bit w, input logic [7:0] pg, input logic [31:0] wd,
                      input bit en, input logic [127:0] ed, input string tg);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_page = pg; req_wdata = wd;
    q_nak.push_back(en); q_data.push_back(ed); q_chkd.push_back(!w && !en);
    q_tag.push_back(tg);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] pg, input logic [31:0] wd, input bit en,
                    input string tg);
    send(1'b1, pg, wd, en, '0, tg);
  endtask

  task automatic rd(input logic [7:0] pg, input bit en, input logic [127:0] ed,
                    input string tg);
    send(1'b0, pg, '0, en, ed, tg);
  endtask

  task automatic pulse_activate();
    @(negedge clk); activate = 1'b1;
    @(negedge clk); activate = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: resp_valid=%0b expected 0", resp_valid);
    end
    rd(8'h00, 0, 128'h0, "R1 reset contents");
    rd(8'h28, 0, {32'h0, 32'h0000_0030, 32'h0, 32'hBD00_0000}, "R1 threshold reset");

    wr(8'h04, 32'h1111_1111, 0, "R7 write ack");
    wr(8'h05, 32'h2222_2222, 0, "R7 write ack");
    wr(8'h06, 32'h3333_3333, 0, "R7 write ack");
    wr(8'h07, 32'h4444_4444, 0, "R7 write ack");
    rd(8'h04, 0, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, "R2 burst");

    rd(8'h2C, 1, '0, "R3 read above top");
    rd(8'h30, 1, '0, "R3 read far above");

    wr(8'h29, 32'hA5A5_A5A5, 0, "R7 write ack");
    rd(8'h29, 0, {32'h0, 32'h0, 32'h0000_0030, 32'hA5A5_A5A5}, "R4 wrap at top");
    wr(8'h28, 32'h1234_5678, 0, "R7 write ack");
    rd(8'h28, 0, {32'h0, 32'h0000_0030, 32'hA5A5_A5A5, 32'hBD34_5678}, "R14 fixed byte");
    wr(8'h2C, 32'hCAFE_F00D, 0, "R8 key write ack");

    wr(8'h01, 32'hFFFF_FFFF, 1, "R7 write below range");
    wr(8'h30, 32'hFFFF_FFFF, 1, "R7 write above range");
    rd(8'h00, 0, 128'h0, "R7 memory untouched");

    wr(8'h03, 32'h0705_FCFF, 0, "R10 otp first");
    wr(8'h03, 32'h8039_00FF, 0, "R10 otp second");
    rd(8'h03, 0, {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h873D_FCFF}, "R10 otp or");

    wr(8'h02, 32'h0010_FFFF, 0, "R9 lock write");
    rd(8'h02, 0, {32'h2222_2222, 32'h1111_1111, 32'h873D_FCFF, 32'h0010_0000}, "R9 low bytes kept");
    wr(8'h02, 32'h0020_0000, 0, "R9 lock write");

    wr(8'h04, 32'h5555_5555, 0, "R13 lock not yet active");
    rd(8'h04, 0, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h5555_5555}, "R13 write landed");

    pulse_activate();
    wr(8'h04, 32'h6666_6666, 1, "R11 locked page 4");
    wr(8'h05, 32'h0000_0000, 1, "R11 locked page 5");
    wr(8'h06, 32'h7777_7777, 0, "R11 unlocked page 6");
    rd(8'h04, 0, {32'h4444_4444, 32'h7777_7777, 32'h2222_2222, 32'h5555_5555}, "R11 locked pages kept");

    wr(8'h02, 32'h0002_0000, 0, "R12 set block lock");
    pulse_activate();
    wr(8'h02, 32'h0088_0000, 0, "R12 frozen write ack");
    rd(8'h02, 0, {32'h2222_2222, 32'h5555_5555, 32'h873D_FCFF, 32'h003A_0000}, "R12 frozen bit");
    rd(8'h2B, 0, {32'h003A_0000, 32'h0, 32'h0, 32'h0}, "R8 key hidden");

    wr(8'h2A, 32'h0000_0006, 0, "R5 set threshold");
    rd(8'h04, 0, {32'h0, 32'h0, 32'h2222_2222, 32'h5555_5555}, "R5 wrap before threshold");
    rd(8'h06, 1, '0, "R5 read at threshold");
    wr(8'h06, 32'h0, 1, "R5 write at threshold");
    @(negedge clk); authed = 1'b1;
    rd(8'h06, 0, {32'h0, 32'h0, 32'h4444_4444, 32'h7777_7777}, "R5 authed read");

    wr(8'h2B, 32'h0000_0001, 0, "R6 write-only mode");
    @(negedge clk); authed = 1'b0;
    rd(8'h06, 0, {32'h0, 32'h0, 32'h4444_4444, 32'h7777_7777}, "R6 read open");
    wr(8'h07, 32'h8888_8888, 1, "R6 write guarded");
    @(negedge clk); authed = 1'b1;
    wr(8'h07, 32'h8888_8888, 0, "R6 authed write");
    rd(8'h07, 0, {32'h0, 32'h0, 32'h0, 32'h8888_8888}, "R6 authed write landed");

    repeat (4) @(negedge clk);
    checks++;
    if (q_nak.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d responses missing expected 0", q_nak.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule